// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment is shifted left by four bit positions and the offset is added, so every segment begins on a 16-byte boundary and covers 64 KB. The block holds four segment registers: code, data, stack and extra. It picks one of them from the access class of each request. The offset comes from the internal instruction pointer for fetches and from the stack pointer input for stack accesses. For data and extra accesses it comes from either an index input or an immediate input.

The block also keeps the instruction pointer. The pointer advances by the length of each fetched instruction and wraps inside its 64 KB segment. A direct load of the pointer takes priority over an advance. A separate access class produces the address of an interrupt-table entry: the type number times four, with no segment involved. Reset loads the code segment with all ones and clears the pointer, so the first fetch addresses the top 16-byte area of the 1 MB space.

A request is sampled on one clock edge, and its address appears on the registered output after that edge together with a valid flag.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the code segment to FFFF, the data, stack and extra segments to 0000, the instruction pointer to 0000 and addr_valid to 0. A fetch issued right after reset therefore yields address FFFF0.
- R2: Every segmented address equals (segment × 16 + offset) modulo 2^20. For example, segment FFFF with offset 0010 gives 00000.
- R3: Access class 0 (fetch) uses the code segment and the instruction pointer value held before the edge that samples the request. For example, code segment 1234 with pointer 0012 gives 12352.
- R4: Access class 1 (data) uses the data segment. Its offset is idx_in when imm_sel is 0 and imm_in when imm_sel is 1.
- R5: Access class 2 (stack) uses the stack segment with sp_in as the offset. idx_in, imm_in and imm_sel have no effect.
- R6: Access class 3 (extra) uses the extra segment and selects its offset with imm_sel in the same way as R4.
- R7: Access class 4 (vector) yields vec_type × 4, zero-extended to 20 bits. The result always lies in 00000 to 003FC, and no segment register affects it.
- R8: When ip_adv_en is high and ip_ld_en is low, the pointer becomes (pointer + ip_adv_len) modulo 2^16 at the edge. For example, 0012 advanced by 2 gives 0014, and FFFF advanced by 3 gives 0002.
- R9: When ip_ld_en is high, the pointer takes ip_ld_val at the edge, whatever ip_adv_en is.
- R10: seg_wr_en writes seg_wr_data into the register chosen by seg_wr_sel (0 code, 1 data, 2 stack, 3 extra) at the edge. A request sampled at that same edge still sees the old value.
- R11: addr_valid equals req_valid from the previous edge. While req_valid is low, phys_addr keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request an address this cycle |
| acc_class | input | 3 | 0 fetch, 1 data, 2 stack, 3 extra, 4 vector |
| sp_in | input | 16 | Stack pointer offset |
| idx_in | input | 16 | Index register offset |
| imm_in | input | 16 | Immediate offset |
| imm_sel | input | 1 | Data/extra offset: 0 index, 1 immediate |
| vec_type | input | 8 | Interrupt type number |
| seg_wr_en | input | 1 | Write a segment register |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Segment write value |
| ip_ld_en | input | 1 | Load the instruction pointer |
| ip_ld_val | input | 16 | Pointer load value |
| ip_adv_en | input | 1 | Advance the pointer |
| ip_adv_len | input | 3 | Advance amount in bytes |
| phys_addr | output | 20 | Registered physical address |
| addr_valid | output | 1 | phys_addr holds a new result |
| ip_out | output | 16 | Current instruction pointer |

## Verification
The random stimulus drives all five access classes with full-range segment, offset and pointer values. Many of these sums carry out of bit 19, so a wrong shift or width shows up as an address mismatch. Segment writes and pointer loads or advances land in the same cycle as requests. This separates designs that read the old register value from designs that forward the new one. Directed cases cover the reset fetch at FFFF0, the 1234:0012 fetch, pointer wrap at FFFF, segment wrap to 00000, the highest vector entry, and load-over-advance priority. Stack requests with changing index and immediate inputs show that those inputs are ignored.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int SEG_W        = 16;
    localparam int OFF_W        = 16;
    localparam int SEG_SHIFT    = 4;
    localparam int ADDR_W       = SEG_W + SEG_SHIFT;
    localparam int LEN_W        = 3;
    localparam int VEC_W        = 8;
    localparam int VEC_ENTRY_SH = 2;
    localparam int NUM_SEG      = 4;
    localparam int SEL_W        = $clog2(NUM_SEG);
    localparam int CLASS_W      = 3;

    localparam logic [SEG_W-1:0] RESET_CODE_SEG = '1;
    localparam logic [SEG_W-1:0] RESET_OTHER_SEG = '0;
    localparam logic [OFF_W-1:0] RESET_IP = '0;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [CLASS_W-1:0] {
        ACC_FETCH  = 3'd0,
        ACC_DATA   = 3'd1,
        ACC_STACK  = 3'd2,
        ACC_EXTRA  = 3'd3,
        ACC_VECTOR = 3'd4
    } acc_class_e;

    typedef struct packed {
        logic             is_vec;
        seg_id_e          seg;
        logic [OFF_W-1:0] off;
    } route_t;

    function automatic logic [ADDR_W-1:0] seg_phys(input logic [SEG_W-1:0] seg,
                                                   input logic [OFF_W-1:0] off);
        logic [ADDR_W-1:0] base;
        base = {seg, {SEG_SHIFT{1'b0}}};
        return base + ADDR_W'(off);
    endfunction

    function automatic logic [ADDR_W-1:0] vec_phys(input logic [VEC_W-1:0] vec);
        return ADDR_W'({vec, {VEC_ENTRY_SH{1'b0}}});
    endfunction
endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  seg_id_e          wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  seg_id_e          rd_sel,
    output logic [SEG_W-1:0] rd_data
);
    logic [SEG_W-1:0] regs [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL =
            (g == int'(SEG_CODE)) ? RESET_CODE_SEG : RESET_OTHER_SEG;
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= RST_VAL;
            else if (wr_en && (wr_sel == seg_id_e'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_sel];

    // R10: a write lands in the selected register
    a_r10_seg_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/ip_unit.sv
module ip_unit
    import seg_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [OFF_W-1:0] ld_val,
    input  logic             adv_en,
    input  logic [LEN_W-1:0] adv_len,
    output logic [OFF_W-1:0] ip
);
    always_ff @(posedge clk) begin
        if (rst)
            ip <= RESET_IP;
        else if (ld_en)
            ip <= ld_val;
        else if (adv_en)
            ip <= ip + OFF_W'(adv_len);
    end

    a_r8_ip_advance: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !ld_en) |=> ip == OFF_W'($past(ip) + OFF_W'($past(adv_len))));

    a_r9_ip_load: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> ip == $past(ld_val));

    a_r9_ip_idle: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !adv_en) |=> $stable(ip));
endmodule

// File: rtl/acc_router.sv
module acc_router
    import seg_addr_pkg::*;
(
    input  acc_class_e       acc,
    input  logic [OFF_W-1:0] ip,
    input  logic [OFF_W-1:0] sp,
    input  logic [OFF_W-1:0] idx,
    input  logic [OFF_W-1:0] imm,
    input  logic             imm_sel,
    output route_t           route
);
    logic [OFF_W-1:0] data_off;
    assign data_off = imm_sel ? imm : idx;

    always_comb begin
        route = '{is_vec: 1'b0, seg: SEG_DATA, off: data_off};
        unique case (acc)
            ACC_FETCH:  route = '{is_vec: 1'b0, seg: SEG_CODE,  off: ip};
            ACC_DATA:   route = '{is_vec: 1'b0, seg: SEG_DATA,  off: data_off};
            ACC_STACK:  route = '{is_vec: 1'b0, seg: SEG_STACK, off: sp};
            ACC_EXTRA:  route = '{is_vec: 1'b0, seg: SEG_EXTRA, off: data_off};
            ACC_VECTOR: route = '{is_vec: 1'b1, seg: SEG_CODE,  off: '0};
            default:    route = '{is_vec: 1'b0, seg: SEG_DATA,  off: data_off};
        endcase
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CLASS_W-1:0] acc_class,
    input  logic [OFF_W-1:0]   sp_in,
    input  logic [OFF_W-1:0]   idx_in,
    input  logic [OFF_W-1:0]   imm_in,
    input  logic               imm_sel,
    input  logic [VEC_W-1:0]   vec_type,
    input  logic               seg_wr_en,
    input  logic [SEL_W-1:0]   seg_wr_sel,
    input  logic [SEG_W-1:0]   seg_wr_data,
    input  logic               ip_ld_en,
    input  logic [OFF_W-1:0]   ip_ld_val,
    input  logic               ip_adv_en,
    input  logic [LEN_W-1:0]   ip_adv_len,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic               addr_valid,
    output logic [OFF_W-1:0]   ip_out
);
    route_t            route;
    logic [SEG_W-1:0]  seg_val;
    logic [OFF_W-1:0]  ip_cur;
    logic [ADDR_W-1:0] addr_next;

    ip_unit u_ip (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ip_ld_en),
        .ld_val  (ip_ld_val),
        .adv_en  (ip_adv_en),
        .adv_len (ip_adv_len),
        .ip      (ip_cur)
    );

    acc_router u_route (
        .acc     (acc_class_e'(acc_class)),
        .ip      (ip_cur),
        .sp      (sp_in),
        .idx     (idx_in),
        .imm     (imm_in),
        .imm_sel (imm_sel),
        .route   (route)
    );

    seg_bank u_segs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_id_e'(seg_wr_sel)),
        .wr_data (seg_wr_data),
        .rd_sel  (route.seg),
        .rd_data (seg_val)
    );

    assign addr_next = route.is_vec ? vec_phys(vec_type) : seg_phys(seg_val, route.off);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            phys_addr  <= '0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid)
                phys_addr <= addr_next;
        end
    end

    assign ip_out = ip_cur;

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> addr_valid == $past(req_valid));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(phys_addr));

    a_r7_vector_window: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_class == CLASS_W'(ACC_VECTOR)) |=>
            (phys_addr < ADDR_W'(20'h00400)) && (phys_addr[VEC_ENTRY_SH-1:0] == '0));

    a_r5_stack_offset: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_class == CLASS_W'(ACC_STACK)) |-> route.off == sp_in);
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
    logic        clk = 0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  acc_class;
    logic [15:0] sp_in, idx_in, imm_in;
    logic        imm_sel;
    logic [7:0]  vec_type;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        ip_ld_en;
    logic [15:0] ip_ld_val;
    logic        ip_adv_en;
    logic [2:0]  ip_adv_len;
    logic [19:0] phys_addr;
    logic        addr_valid;
    logic [15:0] ip_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_seg [4];
    logic [15:0] m_ip;
    logic [19:0] m_addr;

    always #5 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .acc_class(acc_class),
        .sp_in(sp_in), .idx_in(idx_in), .imm_in(imm_in), .imm_sel(imm_sel),
        .vec_type(vec_type), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .ip_ld_en(ip_ld_en), .ip_ld_val(ip_ld_val),
        .ip_adv_en(ip_adv_en), .ip_adv_len(ip_adv_len), .phys_addr(phys_addr),
        .addr_valid(addr_valid), .ip_out(ip_out)
    );

    function automatic logic [19:0] calc(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'h0} + {5'h0, o};
        return full[19:0];
    endfunction

    function automatic logic [19:0] expect_addr();
        logic [15:0] doff;
        doff = imm_sel ? imm_in : idx_in;
        case (acc_class)
            3'd0:    return calc(m_seg[0], m_ip);
            3'd1:    return calc(m_seg[1], doff);
            3'd2:    return calc(m_seg[2], sp_in);
            3'd3:    return calc(m_seg[3], doff);
            default: return {10'h0, vec_type, 2'b00};
        endcase
    endfunction

    function automatic string class_req(input logic [2:0] c);
        case (c)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; acc_class = 0; sp_in = 0; idx_in = 0; imm_in = 0;
        imm_sel = 0; vec_type = 0; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        ip_ld_en = 0; ip_ld_val = 0; ip_adv_en = 0; ip_adv_len = 0;
    endtask

    // Drive is already set; run one edge, check, update the model.
    task automatic tick(input string req);
        logic [19:0] e_addr;
        logic        e_valid;
        logic [15:0] e_ip;
        e_valid = req_valid;
        e_addr  = req_valid ? expect_addr() : m_addr;
        e_ip    = ip_ld_en ? ip_ld_val : (ip_adv_en ? m_ip + 16'(ip_adv_len) : m_ip);
        @(posedge clk);
        #1;
        chk("R11", {31'h0, addr_valid}, {31'h0, e_valid});
        chk(req_adv_tag(), {16'h0, ip_out}, {16'h0, e_ip});
        if (e_valid) chk(req, {12'h0, phys_addr}, {12'h0, e_addr});
        else         chk("R11", {12'h0, phys_addr}, {12'h0, e_addr});
        if (seg_wr_en) m_seg[seg_wr_sel] = seg_wr_data;
        m_ip = e_ip;
        m_addr = e_addr;
    endtask

    function automatic string req_adv_tag();
        return ip_ld_en ? "R9" : "R8";
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240613);
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0;
        m_ip = 0; m_addr = 0;
        // R1: reset state
        chk("R1", {31'h0, addr_valid}, 32'h0);
        chk("R1", {16'h0, ip_out}, 32'h0);

        // R1: first fetch lands at FFFF0
        req_valid = 1; acc_class = 0;
        tick("R1");
        chk("R1", {12'h0, phys_addr}, 32'hFFFF0);

        // R3/R8: example 1234:0012 then advance by 2
        idle();
        seg_wr_en = 1; seg_wr_sel = 0; seg_wr_data = 16'h1234;
        ip_ld_en = 1; ip_ld_val = 16'h0012;
        req_valid = 1; acc_class = 0;       // R10: still sees old CS and old IP
        tick("R10");
        idle();
        req_valid = 1; acc_class = 0; ip_adv_en = 1; ip_adv_len = 2;
        tick("R3");
        chk("R3", {12'h0, phys_addr}, 32'h12352);
        chk("R8", {16'h0, ip_out}, 32'h0014);

        // R8: pointer wrap FFFF + 3 -> 0002
        idle();
        ip_ld_en = 1; ip_ld_val = 16'hFFFF;
        tick("R9");
        idle();
        ip_adv_en = 1; ip_adv_len = 3;
        tick("R8");
        chk("R8", {16'h0, ip_out}, 32'h0002);

        // R9: load beats advance
        idle();
        ip_ld_en = 1; ip_ld_val = 16'hABCD; ip_adv_en = 1; ip_adv_len = 7;
        tick("R9");
        chk("R9", {16'h0, ip_out}, 32'hABCD);

        // R2: segment wrap FFFF:0010 -> 00000 via data class
        idle();
        seg_wr_en = 1; seg_wr_sel = 1; seg_wr_data = 16'hFFFF;
        tick("R10");
        idle();
        req_valid = 1; acc_class = 1; imm_sel = 1; imm_in = 16'h0010; idx_in = 16'h5555;
        tick("R2");
        chk("R2", {12'h0, phys_addr}, 32'h00000);

        // R7: highest vector entry
        idle();
        req_valid = 1; acc_class = 4; vec_type = 8'hFF;
        tick("R7");
        chk("R7", {12'h0, phys_addr}, 32'h003FC);

        // R5: stack ignores index and immediate
        idle();
        seg_wr_en = 1; seg_wr_sel = 2; seg_wr_data = 16'h4500;
        tick("R10");
        idle();
        req_valid = 1; acc_class = 2; sp_in = 16'hFFE0; idx_in = 16'h1111; imm_in = 16'h2222; imm_sel = 1;
        tick("R5");
        chk("R5", {12'h0, phys_addr}, 32'h54FE0);

        // R11: hold while idle
        idle();
        idx_in = 16'h7777; acc_class = 1;
        tick("R11");
        chk("R11", {12'h0, phys_addr}, 32'h54FE0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            idle();
            c = 3'($urandom % 5);
            req_valid = ($urandom % 4) != 0;
            acc_class = c;
            sp_in = 16'($urandom); idx_in = 16'($urandom); imm_in = 16'($urandom);
            imm_sel = 1'($urandom); vec_type = 8'($urandom);
            seg_wr_en = ($urandom % 3) == 0;
            seg_wr_sel = 2'($urandom); seg_wr_data = 16'($urandom);
            ip_ld_en = ($urandom % 8) == 0; ip_ld_val = 16'($urandom);
            ip_adv_en = 1'($urandom); ip_adv_len = 3'($urandom);
            tick(class_req(c));
        end

        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule